// File: doc/BRIEF.md
# Segmented SIMD Adder/Subtracter

This block is a 48-bit adder/subtracter built from four 12-bit segments. A mode input decides how the segments are grouped into lanes: one 48-bit lane, two 24-bit lanes, or four 12-bit lanes. The carry chain is cut wherever a lane ends, so each lane adds or subtracts on its own and wraps within its own width. Each 12-bit segment has a carry-out bit. In each mode, the bits that do not mark a lane end are forced to zero.

The first operand (Z) is always the 48-bit `c_in` word. The second operand (X) is chosen by a select input from three sources: zero, the word formed by placing the 30-bit `a_in` above the 18-bit `b_in`, or an externally supplied product word. The product source is only allowed in single-lane mode. In both split modes it is ignored and behaves as zero. A carry input enters the bottom of every lane. When subtracting, each lane computes Z − (X + carry_in). The result and the carry vector pass through an optional output register with a synchronous reset.

Top module: `simd_lane_adder`

## Requirements
- R1: `lane_mode` encoding: 0 gives one 48-bit lane, 1 gives two 24-bit lanes (bits 23:0 and 47:24), 2 gives four 12-bit lanes, and 3 behaves like 0. Each lane's result is computed modulo 2^width, and no carry crosses from one lane into the next.
- R2: With `x_sel` = 1, X equals `a_in` in bits 47:18 and `b_in` in bits 17:0.
- R3: In four-lane mode, `carry_out[k]` is the carry-out of segment k, which covers bits 12k+11 down to 12k.
- R4: In two-lane mode, `carry_out[1]` and `carry_out[3]` are the carries of the lower and upper lanes, and `carry_out[0]` and `carry_out[2]` are 0.
- R5: In single-lane mode, `carry_out[3]` is the 48-bit carry and `carry_out[2:0]` is 0.
- R6: With `sub` = 1, each lane gives Z − X − `carry_in` modulo 2^width. Its carry bit is 1 exactly when Z ≥ X + `carry_in`, that is, when there is no borrow.
- R7: With `sub` = 0, each lane gives Z + X + `carry_in`. `carry_in` enters at the least significant bit of every lane.
- R8: With `x_sel` = 2, X equals `prod_in` in single-lane mode. In both split modes this selection is ignored and X is zero.
- R9: With `x_sel` = 0 or 3, X is zero.
- R10: With the output register present (the default), `sum_out` and `carry_out` follow the inputs one clock later. A high `rst` at a clock edge sets both to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the output register |
| lane_mode | input | 2 | Lane grouping: 0 = one lane, 1 = two lanes, 2 = four lanes, 3 = one lane |
| x_sel | input | 2 | X source: 0 = zero, 1 = {a_in,b_in}, 2 = prod_in, 3 = zero |
| sub | input | 1 | 0 = add, 1 = subtract X and carry from Z |
| carry_in | input | 1 | Carry/borrow injected at each lane's least significant bit |
| a_in | input | 30 | Upper part of the concatenated operand |
| b_in | input | 18 | Lower part of the concatenated operand |
| prod_in | input | 48 | Product word, used only in single-lane mode |
| c_in | input | 48 | Z operand |
| sum_out | output | 48 | Lane results |
| carry_out | output | 4 | Per-segment carry, with non-lane-end bits forced to zero |

## Verification
A wrong lane-start decision leaks a carry into the next lane or drops one. This shows up in the very next registered result as a sum that is off by one at the lane's base bit. Directed operands that fill every segment with ones make that leak visible in one cycle. A wrong lane-end mask shows as a stray or missing bit in `carry_out` in that same cycle. A mishandled product select shows as `sum_out` differing from `c_in` under a zero-carry add. Random operands across all four mode codes, in both directions, cover the remaining combinations against a per-lane reference.

// File: rtl/simd_add_pkg.sv
package simd_add_pkg;

   typedef enum logic [1:0] {
      LM_ONE  = 2'd0,
      LM_TWO  = 2'd1,
      LM_FOUR = 2'd2,
      LM_ALT  = 2'd3
   } lane_mode_e;

   typedef enum logic [1:0] {
      XS_ZERO = 2'd0,
      XS_CAT  = 2'd1,
      XS_PROD = 2'd2,
      XS_OFF  = 2'd3
   } xsrc_e;

endpackage

// File: rtl/simd_operand_sel.sv
module simd_operand_sel
   import simd_add_pkg::*;
#(
   parameter int A_W    = 30,
   parameter int B_W    = 18,
   parameter int DATA_W = 48
) (
   input  logic [1:0]        x_sel,
   input  logic              split,
   input  logic [A_W-1:0]    a_in,
   input  logic [B_W-1:0]    b_in,
   input  logic [DATA_W-1:0] prod_in,
   output logic [DATA_W-1:0] x_op
);

   xsrc_e src;
   assign src = xsrc_e'(x_sel);

   always_comb begin
      case (src)
         XS_CAT:  x_op = {a_in, b_in};
         // the product path is only legal when the chain is unbroken
         XS_PROD: x_op = split ? '0 : prod_in;
         default: x_op = '0;
      endcase
   end

endmodule

// File: rtl/simd_seg_add.sv
module simd_seg_add #(
   parameter int SEG_W = 12
) (
   input  logic [SEG_W-1:0] z_seg,
   input  logic [SEG_W-1:0] x_seg,
   input  logic             sub,
   input  logic             cin,
   output logic [SEG_W-1:0] s_seg,
   output logic             cout
);

   logic [SEG_W-1:0] x_eff;
   logic [SEG_W:0]   total;

   assign x_eff = sub ? ~x_seg : x_seg;
   assign total = {1'b0, z_seg} + {1'b0, x_eff} + {{SEG_W{1'b0}}, cin};
   assign s_seg = total[SEG_W-1:0];
   assign cout  = total[SEG_W];

endmodule

// File: rtl/simd_out_stage.sv
module simd_out_stage #(
   parameter int DATA_W  = 48,
   parameter int CY_W    = 4,
   parameter int OUT_REG = 1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [DATA_W-1:0] sum_d,
   input  logic [CY_W-1:0]   cy_d,
   output logic [DATA_W-1:0] sum_q,
   output logic [CY_W-1:0]   cy_q
);

   generate
      if (OUT_REG == 1) begin : g_reg
         always_ff @(posedge clk) begin
            if (rst) begin
               sum_q <= '0;
               cy_q  <= '0;
            end else begin
               sum_q <= sum_d;
               cy_q  <= cy_d;
            end
         end
      end else begin : g_comb
         logic unused_ok;
         assign unused_ok = clk ^ rst;
         assign sum_q = sum_d;
         assign cy_q  = cy_d;
      end
   endgenerate

endmodule

// File: rtl/simd_lane_adder.sv
module simd_lane_adder
   import simd_add_pkg::*;
#(
   parameter int SEG_W   = 12,
   parameter int NUM_SEG = 4,
   parameter int A_W     = 30,
   parameter int B_W     = 18,
   parameter int OUT_REG = 1
) (
   input  logic                       clk,
   input  logic                       rst,
   input  logic [1:0]                 lane_mode,
   input  logic [1:0]                 x_sel,
   input  logic                       sub,
   input  logic                       carry_in,
   input  logic [A_W-1:0]             a_in,
   input  logic [B_W-1:0]             b_in,
   input  logic [SEG_W*NUM_SEG-1:0]   prod_in,
   input  logic [SEG_W*NUM_SEG-1:0]   c_in,
   output logic [SEG_W*NUM_SEG-1:0]   sum_out,
   output logic [NUM_SEG-1:0]         carry_out
);

   localparam int DATA_W = SEG_W * NUM_SEG;

   generate
      if (NUM_SEG != 4) begin : g_bad_seg
         $error("simd_lane_adder: NUM_SEG must be 4");
      end
      if (A_W + B_W != DATA_W) begin : g_bad_cat
         $error("simd_lane_adder: A_W + B_W must equal SEG_W*NUM_SEG");
      end
      if (OUT_REG != 0 && OUT_REG != 1) begin : g_bad_reg
         $error("simd_lane_adder: OUT_REG must be 0 or 1");
      end
   endgenerate

   lane_mode_e mode;
   logic       split;
   logic       lane_cin;
   logic [DATA_W-1:0]  x_op;
   logic [DATA_W-1:0]  sum_nxt;
   logic [NUM_SEG-1:0] seg_co;
   logic [NUM_SEG-1:0] seg_ci;
   logic [NUM_SEG-1:0] lane_start;
   logic [NUM_SEG-1:0] lane_end;
   logic [NUM_SEG-1:0] cy_nxt;

   assign mode     = lane_mode_e'(lane_mode);
   assign split    = (mode == LM_TWO) || (mode == LM_FOUR);
   // subtraction feeds an inverted borrow as the carry into each lane
   assign lane_cin = sub ? ~carry_in : carry_in;

   simd_operand_sel #(
      .A_W    (A_W),
      .B_W    (B_W),
      .DATA_W (DATA_W)
   ) u_xsel (
      .x_sel   (x_sel),
      .split   (split),
      .a_in    (a_in),
      .b_in    (b_in),
      .prod_in (prod_in),
      .x_op    (x_op)
   );

   generate
      for (genvar k = 0; k < NUM_SEG; k++) begin : g_seg
         localparam bit EVEN_SEG = (k % 2) == 0;
         localparam bit TOP_SEG  = (k == NUM_SEG - 1);
         localparam bit BOT_SEG  = (k == 0);

         assign lane_start[k] = BOT_SEG || (mode == LM_FOUR) ||
                                ((mode == LM_TWO) && EVEN_SEG);
         assign lane_end[k]   = TOP_SEG || (mode == LM_FOUR) ||
                                ((mode == LM_TWO) && !EVEN_SEG);

         if (k == 0) begin : g_first
            assign seg_ci[k] = lane_cin;
         end else begin : g_rest
            assign seg_ci[k] = lane_start[k] ? lane_cin : seg_co[k-1];
         end

         simd_seg_add #(.SEG_W(SEG_W)) u_seg (
            .z_seg (c_in[k*SEG_W +: SEG_W]),
            .x_seg (x_op[k*SEG_W +: SEG_W]),
            .sub   (sub),
            .cin   (seg_ci[k]),
            .s_seg (sum_nxt[k*SEG_W +: SEG_W]),
            .cout  (seg_co[k])
         );
      end
   endgenerate

   assign cy_nxt = seg_co & lane_end;

   simd_out_stage #(
      .DATA_W  (DATA_W),
      .CY_W    (NUM_SEG),
      .OUT_REG (OUT_REG)
   ) u_out (
      .clk   (clk),
      .rst   (rst),
      .sum_d (sum_nxt),
      .cy_d  (cy_nxt),
      .sum_q (sum_out),
      .cy_q  (carry_out)
   );

endmodule

// File: rtl/simd_lane_adder_chk.sv
module simd_lane_adder_chk #(
   parameter int SEG_W   = 12,
   parameter int NUM_SEG = 4,
   parameter int OUT_REG = 1
) (
   input logic                     clk,
   input logic                     rst,
   input logic [1:0]               lane_mode,
   input logic [1:0]               x_sel,
   input logic                     sub,
   input logic                     carry_in,
   input logic [SEG_W*NUM_SEG-1:0] c_in,
   input logic [SEG_W*NUM_SEG-1:0] sum_out,
   input logic [NUM_SEG-1:0]       carry_out
);

   logic split_mode;
   assign split_mode = (lane_mode == 2'd1) || (lane_mode == 2'd2);

   generate
      if (OUT_REG == 1) begin : g_chk
         // R10
         reset_clears_chk: assert property (@(posedge clk)
            rst |=> (sum_out == '0 && carry_out == '0));

         // R4
         two_lane_even_zero_chk: assert property (@(posedge clk) disable iff (rst)
            (lane_mode == 2'd1) |=> (carry_out[0] == 1'b0 && carry_out[2] == 1'b0));

         // R5
         one_lane_low_zero_chk: assert property (@(posedge clk) disable iff (rst)
            (lane_mode == 2'd0 || lane_mode == 2'd3) |=> (carry_out[NUM_SEG-2:0] == '0));

         // R8
         prod_ignored_chk: assert property (@(posedge clk) disable iff (rst)
            (split_mode && x_sel == 2'd2 && !sub && !carry_in)
            |=> (sum_out == $past(c_in) && carry_out == '0));

         // R9
         zero_operand_chk: assert property (@(posedge clk) disable iff (rst)
            ((x_sel == 2'd0 || x_sel == 2'd3) && !sub && !carry_in)
            |=> (sum_out == $past(c_in) && carry_out == '0));
      end
   endgenerate

endmodule

bind simd_lane_adder simd_lane_adder_chk #(
   .SEG_W   (SEG_W),
   .NUM_SEG (NUM_SEG),
   .OUT_REG (OUT_REG)
) u_chk (
   .clk       (clk),
   .rst       (rst),
   .lane_mode (lane_mode),
   .x_sel     (x_sel),
   .sub       (sub),
   .carry_in  (carry_in),
   .c_in      (c_in),
   .sum_out   (sum_out),
   .carry_out (carry_out)
);

// File: tb/simd_lane_adder_tb.sv
module simd_lane_adder_tb;

   logic        clk = 1'b0;
   logic        rst;
   logic [1:0]  lane_mode;
   logic [1:0]  x_sel;
   logic        sub;
   logic        carry_in;
   logic [29:0] a_in;
   logic [17:0] b_in;
   logic [47:0] prod_in;
   logic [47:0] c_in;
   logic [47:0] sum_out;
   logic [3:0]  carry_out;

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #4 clk = ~clk;

   simd_lane_adder u_dut (
      .clk       (clk),
      .rst       (rst),
      .lane_mode (lane_mode),
      .x_sel     (x_sel),
      .sub       (sub),
      .carry_in  (carry_in),
      .a_in      (a_in),
      .b_in      (b_in),
      .prod_in   (prod_in),
      .c_in      (c_in),
      .sum_out   (sum_out),
      .carry_out (carry_out)
   );

   function automatic logic [51:0] model(input logic [1:0] md, input logic [1:0] xs,
                                         input logic sb, input logic ci,
                                         input logic [29:0] a, input logic [17:0] b,
                                         input logic [47:0] p, input logic [47:0] c);
      logic [47:0] x;
      logic [47:0] s;
      logic [3:0]  cy;
      int          w;
      int          nl;
      bit          split;
      split = (md == 2'd1) || (md == 2'd2);
      case (xs)
         2'd1:    x = {a, b};
         2'd2:    x = split ? 48'd0 : p;
         default: x = 48'd0;
      endcase
      w  = (md == 2'd1) ? 24 : (md == 2'd2) ? 12 : 48;
      nl = 48 / w;
      s  = '0;
      cy = '0;
      for (int i = 0; i < nl; i++) begin
         longint unsigned msk;
         longint unsigned zi;
         longint unsigned xi;
         longint          t;
         longint unsigned r;
         bit              c_bit;
         msk = (64'd1 << w) - 64'd1;
         zi  = (64'(c) >> (i * w)) & msk;
         xi  = (64'(x) >> (i * w)) & msk;
         if (!sb) begin
            t     = longint'(zi + xi + 64'(ci));
            c_bit = ((t >> w) & 64'd1) != 0;
         end else begin
            t     = longint'(zi) - longint'(xi) - longint'(ci);
            c_bit = (t >= 0);
         end
         r = longint'(t) & msk;
         s = s | 48'(r << (i * w));
         cy[(i + 1) * (w / 12) - 1] = c_bit;
      end
      return {cy, s};
   endfunction

   task automatic check(input string tag, input logic [51:0] got, input logic [51:0] exp);
      n_cmp++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s got carry=%h sum=%h exp carry=%h sum=%h",
                  tag, got[51:48], got[47:0], exp[51:48], exp[47:0]);
      end
   endtask

   task automatic run_op(input string tag, input logic [1:0] md, input logic [1:0] xs,
                         input logic sb, input logic ci, input logic [47:0] xcat,
                         input logic [47:0] p, input logic [47:0] c);
      logic [51:0] exp;
      @(negedge clk);
      lane_mode = md;
      x_sel     = xs;
      sub       = sb;
      carry_in  = ci;
      a_in      = xcat[47:18];
      b_in      = xcat[17:0];
      prod_in   = p;
      c_in      = c;
      exp = model(md, xs, sb, ci, xcat[47:18], xcat[17:0], p, c);
      @(negedge clk);
      check(tag, {carry_out, sum_out}, exp);
   endtask

   task automatic summary;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   initial begin
      #(8 * 150000);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog R10 got=hung exp=finished");
         summary();
         $finish;
      end
   end

   initial begin
      rst       = 1'b1;
      lane_mode = 2'd2;
      x_sel     = 2'd1;
      sub       = 1'b0;
      carry_in  = 1'b1;
      a_in      = 30'h3FFF_FFFF;
      b_in      = 18'h3_FFFF;
      prod_in   = 48'h1234_5678_9ABC;
      c_in      = 48'hFFFF_FFFF_FFFF;
      void'($urandom(32'd2024));
      repeat (3) @(negedge clk);
      // R10 reset state
      check("R10 reset", {carry_out, sum_out}, 52'd0);
      rst = 1'b0;

      // R5 full 48-bit carry
      run_op("R5 single carry", 2'd0, 2'd1, 1'b0, 1'b0, 48'hFFFF_FFFF_FFFF, 48'd0, 48'd1);
      // R3 R1 four lanes each overflow independently
      run_op("R3 four overflow", 2'd2, 2'd1, 1'b0, 1'b0, 48'h001_001_001_001, 48'd0,
             48'hFFF_FFF_FFF_FFF);
      // R4 R1 two lanes overflow, no crossing
      run_op("R4 two overflow", 2'd1, 2'd1, 1'b0, 1'b0, 48'h000001_000001, 48'd0,
             48'hFFFFFF_FFFFFF);
      // R2 concatenation placement
      run_op("R2 concat", 2'd0, 2'd1, 1'b0, 1'b0, {30'h2AAA_5555, 18'h1_2345}, 48'd0, 48'd0);
      // R6 borrow in each 12-bit lane
      run_op("R6 borrow", 2'd2, 2'd0, 1'b1, 1'b1, 48'd0, 48'd0, 48'd0);
      // R6 exact difference, no borrow
      run_op("R6 no borrow", 2'd1, 2'd1, 1'b1, 1'b0, 48'h000005_000700, 48'd0,
             48'h000005_000700);
      // R7 carry into every lane
      run_op("R7 lane cin", 2'd1, 2'd0, 1'b0, 1'b1, 48'd0, 48'd0, 48'h00_0000_0000);
      run_op("R7 lane cin 12", 2'd2, 2'd0, 1'b0, 1'b1, 48'd0, 48'd0, 48'h0FF_FFF_0FF_FFF);
      // R8 product ignored in split modes, used in single lane
      run_op("R8 prod split4", 2'd2, 2'd2, 1'b0, 1'b0, 48'd0, 48'hFFFF_FFFF_FFFF,
             48'h1357_9BDF_2468);
      run_op("R8 prod split2", 2'd1, 2'd2, 1'b1, 1'b0, 48'd0, 48'h8000_0000_0001,
             48'h0ACE_0000_0001);
      run_op("R8 prod single", 2'd0, 2'd2, 1'b0, 1'b0, 48'd0, 48'h0000_1111_2222,
             48'h0000_0001_0001);
      // R9 zero source codes
      run_op("R9 zero off", 2'd0, 2'd3, 1'b0, 1'b0, 48'hFFFF_FFFF_FFFF, 48'hFFFF_FFFF_FFFF,
             48'h0BAD_0000_F00D);
      // R1 code 3 behaves as single lane
      run_op("R1 code3", 2'd3, 2'd1, 1'b0, 1'b1, 48'h0000_00FF_FFFF, 48'd0, 48'h0000_0000_0000);

      // R10 synchronous reset mid-run
      @(negedge clk);
      rst = 1'b1;
      c_in = 48'h7777_7777_7777;
      @(negedge clk);
      check("R10 mid reset", {carry_out, sum_out}, 52'd0);
      rst = 1'b0;

      // R1 random operands across all mode codes
      for (int n = 0; n < 1500; n++) begin
         logic [47:0] rx;
         logic [47:0] rp;
         logic [47:0] rc;
         logic [1:0]  rm;
         logic [1:0]  rs;
         rx = {$urandom(), $urandom()};
         rp = {$urandom(), $urandom()};
         rc = {$urandom(), $urandom()};
         if (n % 7 == 0) rc = 48'hFFFF_FFFF_FFFF;
         if (n % 11 == 0) rx = rc;
         rm = 2'($urandom());
         rs = 2'($urandom());
         run_op("R1 random", rm, rs, 1'($urandom()), 1'($urandom()), rx, rp, rc);
      end

      done = 1'b1;
      summary();
      $finish;
   end

endmodule